// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that is read or written in bursts of four beats. A single control line decides, at each rising clock edge, whether a fresh base address is captured from outside or whether the next address of the current burst is generated internally. Only the two low address bits move during a burst. The upper bits stay as they were captured.

An ordering input picks between two sequences. The linear order counts the low bits upward, modulo four, from the captured offset. The interleaved order XORs the captured offset with a running beat count. The ordering is sampled together with the base address, so it stays fixed for the whole burst. A clock-enable input freezes every register, so a burst can be suspended in the middle and resumed later. The outputs come straight from registers: the full address, the two-bit beat offset, and a flag that is set while the current address is a continuation beat and not a freshly loaded one.

All ports are plain level signals with no valid/ready handshake. A new address can be accepted on every enabled edge, and the only form of back-pressure is holding the clock enable low.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset, which takes priority over the clock enable, drives `cur_addr` to 0, `beat_ofs` to 0 and `cont_beat` to 0 after the edge.
- R2: On an edge where `clk_en`=1 and `adv_nload`=0, `cur_addr` becomes `load_addr` after the edge. On the same edge `cont_beat` becomes 0 and `order_sel` is captured (0 = linear, 1 = interleaved).
- R3: In linear order, the beat offset on the n-th advance after a load is (captured low two bits + n) mod 4. For example, offset 2 gives the sequence 2,3,0,1.
- R4: In interleaved order, the beat offset on the n-th advance is the captured low two bits XOR (n mod 4).
- R5: An advance never changes `cur_addr` above bit 1. There is no carry out of the low two bits.
- R6: After four advances the offset returns to the captured value. Further advances keep cycling within the same four-word block.
- R7: While `clk_en`=0, all outputs hold their values, whatever `adv_nload`, `order_sel` and `load_addr` are doing.
- R8: `cont_beat` is 1 after an enabled advance and 0 after an enabled load.
- R9: A change of `order_sel` between loads has no effect on the sequence until the next load.
- R10: An advance after reset with no load yet steps linearly from address 0.
- R11: `beat_ofs` always equals bits [1:0] of `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | 1 = edge takes effect, 0 = all state frozen |
| adv_nload | input | 1 | 0 = capture base address, 1 = advance burst |
| order_sel | input | 1 | Burst order sampled at load: 0 linear, 1 interleaved |
| load_addr | input | ADDR_W | External base address |
| cur_addr | output | ADDR_W | Current word address |
| beat_ofs | output | 2 | Current low-order beat offset |
| cont_beat | output | 1 | 1 when the current address came from an advance |

## Verification
Every output is a register or a direct function of registers, so a wrong internal state shows up on `cur_addr` in the cycle right after the edge that caused it. A corrupted beat count or a wrongly latched order gives a wrong offset on the next advance. It stays wrong on every later beat until a reload, and this is why each burst in the bench runs through a full wrap. A leak through the clock enable, or a carry into the upper bits, shows up as a change in an address that should have been frozen. That change is visible one edge after the stimulus.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic                     order_in,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]        base_lo_q,
  output burst_order_e             order_q
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q   <= '0;
      base_lo_q <= '0;
      order_q   <= ORD_LINEAR;
    end else if (load) begin
      upper_q   <= load_addr[ADDR_W-1:BEAT_W];
      base_lo_q <= load_addr[BEAT_W-1:0];
      order_q   <= burst_order_e'(order_in);
    end
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(upper_q)) else $error("upper bits moved without load"); // R5
  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(order_q)) else $error("order changed without load"); // R9
  AST_LOAD_CAPT: assert property (@(posedge clk) disable iff (rst)
    load |=> upper_q == $past(load_addr[ADDR_W-1:BEAT_W])) else $error("base not captured"); // R2

  logic [UP_W-1:0] unused_w;
  assign unused_w = upper_q;
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q,
  output logic              cont_q
);
  localparam logic [BEAT_W-1:0] CNT_ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_q + CNT_ONE;
      cont_q <= 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> cnt_q == $past(cnt_q) + CNT_ONE) else $error("beat count step"); // R6
  AST_CONT_SET: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> cont_q) else $error("continuation flag not set"); // R8
  AST_LOAD_CLR: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0) && !cont_q) else $error("load did not clear count"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load && !step |=> $stable(cnt_q) && $stable(cont_q)) else $error("count moved while idle"); // R7
endmodule

// File: rtl/bseq_ofs_gen.sv
module bseq_ofs_gen
  import bseq_pkg::*;
(
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] cnt,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] ofs
);
  logic [BEAT_W-1:0] lin_ofs;
  logic [BEAT_W-1:0] xor_ofs;

  assign lin_ofs = base_lo + cnt;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_ofs[b] = base_lo[b] ^ cnt[b];
  end

  always_comb begin
    unique case (order)
      ORD_XOR:    ofs = xor_ofs;
      default:    ofs = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              adv_nload,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat_ofs,
  output logic              cont_beat
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic              do_load;
  logic              do_step;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] base_lo_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] ofs;
  burst_order_e      order_q;

  assign do_load = clk_en && !adv_nload;
  assign do_step = clk_en &&  adv_nload;

  bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .load      (do_load),
    .load_addr (load_addr),
    .order_in  (order_sel),
    .upper_q   (upper_q),
    .base_lo_q (base_lo_q),
    .order_q   (order_q)
  );

  bseq_beat_ctr u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (do_load),
    .step   (do_step),
    .cnt_q  (cnt_q),
    .cont_q (cont_beat)
  );

  bseq_ofs_gen u_ofs (
    .base_lo (base_lo_q),
    .cnt     (cnt_q),
    .order   (order_q),
    .ofs     (ofs)
  );

  assign cur_addr = {upper_q, ofs};
  assign beat_ofs = ofs;

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(cur_addr) && $stable(cont_beat)) else $error("state moved while frozen"); // R7
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    do_load |=> cur_addr == $past(load_addr)) else $error("loaded address wrong"); // R2
  AST_ADV_UPPER: assert property (@(posedge clk) disable iff (rst)
    do_step |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])) else $error("carry into upper bits"); // R5
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (cur_addr == '0) && !cont_beat) else $error("reset state"); // R1
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int unsigned AW = 18;

  typedef struct packed {
    logic          en;
    logic          adv;
    logic          ord;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp_addr;
    logic          exp_cont;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 18'h12346, 18'h12346, 1'b0}, // R2 load linear
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h12347, 1'b1}, // R3
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h12344, 1'b1}, // R3 R5
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h12345, 1'b1}, // R3
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h12346, 1'b1}, // R6 wrap
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h12347, 1'b1}, // R6
    '{1'b1, 1'b0, 1'b1, 18'h0ABC1, 18'h0ABC1, 1'b0}, // R2 R8 load xor
    '{1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h0ABC0, 1'b1}, // R4 R9
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h0ABC3, 1'b1}, // R4
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h0ABC2, 1'b1}, // R4
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h0ABC1, 1'b1}, // R6
    '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h0ABC1, 1'b1}, // R7 load masked
    '{1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h0ABC1, 1'b1}, // R7 step masked
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h0ABC0, 1'b1}, // R7 resume
    '{1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 1'b0}, // R2
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h3FFFC, 1'b1}, // R5 no carry
    '{1'b1, 1'b0, 1'b1, 18'h00002, 18'h00002, 1'b0}, // R2
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h00003, 1'b1}, // R4
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h00000, 1'b1}  // R4
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          clk_en;
  logic          adv_nload;
  logic          order_sel;
  logic [AW-1:0] load_addr;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat_ofs;
  logic          cont_beat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .adv_nload (adv_nload),
    .order_sel (order_sel),
    .load_addr (load_addr),
    .cur_addr  (cur_addr),
    .beat_ofs  (beat_ofs),
    .cont_beat (cont_beat)
  );

  task automatic check(string req, logic [AW-1:0] ea, logic ec);
    checks++;
    if (cur_addr !== ea || cont_beat !== ec || beat_ofs !== ea[1:0]) begin
      fails++;
      $display("FAIL %s: addr=%h ofs=%0d cont=%0b expected addr=%h ofs=%0d cont=%0b",
               req, cur_addr, beat_ofs, cont_beat, ea, ea[1:0], ec);
    end
  endtask

  task automatic drive(logic r, logic en, logic adv, logic ord, logic [AW-1:0] a);
    rst = r; clk_en = en; adv_nload = adv; order_sel = ord; load_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; clk_en = 1'b0; adv_nload = 1'b1; order_sel = 1'b0; load_addr = '0;
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFFF);
    check("R1 reset", 18'h00000, 1'b0);

    drive(1'b0, 1'b1, 1'b1, 1'b1, 18'h3FFFF);
    check("R10 advance from reset", 18'h00001, 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 18'h00000);
    check("R10 advance from reset", 18'h00002, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(1'b0, TBL[i].en, TBL[i].adv, TBL[i].ord, TBL[i].addr);
      check($sformatf("R11 table step %0d", i), TBL[i].exp_addr, TBL[i].exp_cont);
    end

    drive(1'b1, 1'b1, 1'b1, 1'b0, 18'h00000);
    check("R1 reset mid-burst", 18'h00000, 1'b0);

    drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h2AAAA);
    check("R7 masked load after reset", 18'h00000, 1'b0);

    drive(1'b0, 1'b1, 1'b0, 1'b0, 18'h15551);
    check("R2 load", 18'h15551, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b1, 18'h00000);
      check("R9 linear kept", {16'h5554, 2'((1 + k) % 4)}, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule